// File: doc/BRIEF.md
# Burst SRAM Cycle Controller

This block sits behind the synchronous control pins of a flow-through burst static memory and turns them, clock by clock, into one of three cycle kinds: idle (deselected), read or write. It owns a small 18-bit-wide array built as two 9-bit lanes. Each lane is 8 data bits with a parity bit in its top position, and each lane has its own write enable. A 2-bit burst counter inside the block generates the addresses after the first one. The counter steps in interleaved order by default, and a parameter selects linear order instead.

There are two address strobes, and they follow different rules. The processor strobe counts only when the first chip enable is low, and it always opens a read. The controller strobe opens a read or a write according to the decoded write controls. When both strobes are high, the cycle continues or suspends the current burst and the chip enables are not looked at. Read data flows straight from the array at the registered address during the cycle after the edge. The output-valid flag follows the output enable and the sleep input without waiting for a clock.

Top module: `burst_sram_ctrl`

## Requirements
- R1: A strobe cycle selects the block only when `sel1_n`=0, `sel2_n`=0 and `sel3`=1. A controller-strobe cycle with any enable inactive, or a processor-strobe cycle with `sel1_n`=0 and another enable inactive, makes the block idle. While idle, `dout_en` stays 0, and cycles with both strobes high keep it idle.
- R2: When `sel1_n`=1 the processor strobe is ignored. Such a cycle behaves exactly as if `pstrb_n` were 1.
- R3: A selected processor-strobe cycle is always a read at the new address, whatever the write controls are. The array is left unchanged.
- R4: A selected controller-strobe cycle with `pstrb_n`=1 loads the new address and is a write if the decoded write is active, otherwise a read.
- R5: The decoded write is active when `gw_n`=0, or when `bw_n`=0 and at least one bit of `lane_we_n` is 0. With `gw_n`=0 both lanes are written. Otherwise, with `bw_n`=0, `lane_we_n[0]`=0 writes bits 8:0 and `lane_we_n[1]`=0 writes bits 17:9, where bits 8 and 17 are the parity bits.
- R6: With both strobes high after a non-idle cycle, `adv_n`=0 steps the 2-bit burst count. The low two address bits become the start offset XOR the count (interleaved, default), wrapping after four. The upper address bits are kept.
- R7: With both strobes high and `adv_n`=1, the address is held. Such a cycle reads or writes at the current address according to the decoded write.
- R8: After a processor-strobe read, asserting the write controls in the next cycle (both strobes high, `adv_n`=1) writes the same address.
- R9: `dout_en` is 1 only when `oe_n`=0, `sleep`=0 and the current cycle is a read. During writes it is 0 whatever the value of `oe_n`.
- R10: While `sleep`=1, `dout_en` is 0 at once, no array write happens, and the cycle and address state are held.
- R11: After reset the block is idle and `dout_en` is 0.
- R12: In a read cycle, `dout` carries the word stored at the registered address during the cycle right after the loading edge, with no further register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel1_n | input | 1 | Chip enable 1, active low; gates the processor strobe |
| sel2_n | input | 1 | Chip enable 2, active low |
| sel3 | input | 1 | Chip enable 3, active high |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte-write gate, active low |
| lane_we_n | input | 2 | Per-lane write enables, active low (bit 0 lower lane) |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep, active high, asynchronous |
| addr | input | AW | External address |
| din | input | 18 | Write data |
| dout | output | 18 | Read data |
| dout_en | output | 1 | Read data is being driven |

## Verification
The hardest situation to reach from the ports is a burst that is kept going through continue and suspend cycles while the chip enables are deliberately toggled into invalid patterns. That case shows whether the enables are really ignored outside strobe cycles. The bench reaches it by loading each of the four start offsets with a processor strobe, then stepping and suspending with `sel1_n`, `sel2_n` and `sel3` set to deselecting values. Every word that comes out is compared with an array model whose contents come from a full pattern fill. The write-after-processor-read case is reached the same way, by holding `adv_n` high in the cycle that follows the strobe.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2
  } addr_act_e;
endpackage

// File: rtl/bsram_cmd_decode.sv
module bsram_cmd_decode
  import bsram_pkg::*;
(
  input  logic             sel1_n,
  input  logic             sel2_n,
  input  logic             sel3,
  input  logic             pstrb_n,
  input  logic             cstrb_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] lane_we_n,
  input  cyc_e             cur_cyc,
  output cyc_e             nxt_cyc,
  output addr_act_e        act,
  output logic [LANES-1:0] lane_mask
);
  logic chip_on;
  logic wr_req;
  logic p_taken;

  assign chip_on = !sel1_n && !sel2_n && sel3;
  assign wr_req  = !gw_n || (!bw_n && (lane_we_n != {LANES{1'b1}}));
  assign p_taken = !sel1_n && !pstrb_n;

  always_comb begin
    if (!gw_n)      lane_mask = {LANES{1'b1}};
    else if (!bw_n) lane_mask = ~lane_we_n;
    else            lane_mask = '0;
  end

  always_comb begin
    nxt_cyc = CYC_IDLE;
    act     = ACT_HOLD;
    if (p_taken) begin
      if (chip_on) begin
        nxt_cyc = CYC_READ;
        act     = ACT_LOAD;
      end
    end else if (!cstrb_n) begin
      if (chip_on) begin
        nxt_cyc = wr_req ? CYC_WRITE : CYC_READ;
        act     = ACT_LOAD;
      end
    end else if (cur_cyc != CYC_IDLE) begin
      nxt_cyc = wr_req ? CYC_WRITE : CYC_READ;
      act     = adv_n ? ACT_HOLD : ACT_STEP;
    end
  end
endmodule

// File: rtl/bsram_burst_gen.sv
module bsram_burst_gen
  import bsram_pkg::*;
#(
  parameter int AW           = 6,
  parameter int LINEAR_ORDER = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  addr_act_e     act,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] nxt_addr
);
  localparam int HI_W = AW - 2;

  logic [HI_W-1:0] hi_q, hi_d;
  logic [1:0]      base_q, base_d;
  logic [1:0]      cnt_q, cnt_d;
  logic [1:0]      low_cur, low_nxt;

  always_comb begin
    hi_d   = hi_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    case (act)
      ACT_LOAD: begin
        hi_d   = ext_addr[AW-1:2];
        base_d = ext_addr[1:0];
        cnt_d  = 2'd0;
      end
      ACT_STEP: cnt_d = cnt_q + 2'd1;
      default:  ;
    endcase
  end

  generate
    if (LINEAR_ORDER != 0) begin : g_lin
      assign low_cur = base_q + cnt_q;
      assign low_nxt = base_d + cnt_d;
    end else begin : g_ilv
      assign low_cur = base_q ^ cnt_q;
      assign low_nxt = base_d ^ cnt_d;
    end
  endgenerate

  assign cur_addr = {hi_q, low_cur};
  assign nxt_addr = {hi_d, low_nxt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      hi_q   <= hi_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R6: a step advances the burst count by one, wrapping at four
  assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act == ACT_STEP) |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R7: a suspend leaves the address where it was
  assert_suspend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act == ACT_HOLD) |=> $stable(cur_addr));
endmodule

// File: rtl/bsram_lane_array.sv
module bsram_lane_array
  import bsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (we && lane_mask[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
      assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
  endgenerate
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW           = 6,
  parameter int LINEAR_ORDER = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel1_n,
  input  logic              sel2_n,
  input  logic              sel3,
  input  logic              pstrb_n,
  input  logic              cstrb_n,
  input  logic              adv_n,
  input  logic              gw_n,
  input  logic              bw_n,
  input  logic [1:0]        lane_we_n,
  input  logic              oe_n,
  input  logic              sleep,
  input  logic [AW-1:0]     addr,
  input  logic [17:0]       din,
  output logic [17:0]       dout,
  output logic              dout_en
);
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  cyc_e             cyc_q, cyc_d;
  addr_act_e        act;
  logic [LANES-1:0] lane_mask;
  logic [AW-1:0]    cur_addr, nxt_addr;
  logic             run_en;
  logic             mem_we;

  assign run_en = !sleep;

  bsram_cmd_decode u_dec (
    .sel1_n(sel1_n), .sel2_n(sel2_n), .sel3(sel3),
    .pstrb_n(pstrb_n), .cstrb_n(cstrb_n), .adv_n(adv_n),
    .gw_n(gw_n), .bw_n(bw_n), .lane_we_n(lane_we_n),
    .cur_cyc(cyc_q), .nxt_cyc(cyc_d), .act(act), .lane_mask(lane_mask)
  );

  bsram_burst_gen #(.AW(AW), .LINEAR_ORDER(LINEAR_ORDER)) u_burst (
    .clk(clk), .rst_n(rst_q), .en(run_en), .act(act),
    .ext_addr(addr), .cur_addr(cur_addr), .nxt_addr(nxt_addr)
  );

  assign mem_we = run_en && (cyc_d == CYC_WRITE);

  bsram_lane_array #(.AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .lane_mask(lane_mask), .waddr(nxt_addr),
    .wdata(din), .raddr(cur_addr), .rdata(dout)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      cyc_q <= CYC_IDLE;
    else if (run_en) cyc_q <= cyc_d;
  end

  assign dout_en = run_en && !oe_n && (cyc_q == CYC_READ);

  // R1: a controller strobe with enable 3 low leaves the block idle
  assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (!sleep && !cstrb_n && pstrb_n && !sel3) |=> !dout_en);

  // R3: a selected processor strobe never opens a write
  assert_pstrb_read_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (!sleep && !sel1_n && !pstrb_n) |=> (cyc_q != CYC_WRITE));

  // R5: any array write carries at least one lane
  assert_write_has_lane_R5: assert property (@(posedge clk) disable iff (!rst_q)
    mem_we |-> (lane_mask != 2'b00));

  // R9: output flag requires output enable and no sleep
  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (oe_n || sleep) |-> !dout_en);

  // R10: sleep blocks writes and freezes the cycle state
  assert_sleep_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_q)
    sleep |-> !mem_we);
  assert_sleep_hold_R10: assert property (@(posedge clk) disable iff (!rst_q)
    sleep |=> $stable(cyc_q));
endmodule

// File: tb/sim_burst_sram_ctrl.sv
module sim_burst_sram_ctrl;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic s1, s2, s3, pp, cc, av, gw, bw, oe, slp;
  logic [1:0]  lw;
  logic [AW-1:0] ad;
  logic [17:0] di;
  logic [17:0] dout;
  logic        dout_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int m_cyc;
  logic [AW-3:0] m_hi;
  logic [1:0] m_base, m_cnt;
  logic [17:0] ref_mem [DEPTH];

  always #5 clk = ~clk;

  burst_sram_ctrl #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .sel1_n(s1), .sel2_n(s2), .sel3(s3),
    .pstrb_n(pp), .cstrb_n(cc), .adv_n(av), .gw_n(gw), .bw_n(bw),
    .lane_we_n(lw), .oe_n(oe), .sleep(slp), .addr(ad), .din(di),
    .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [17:0] pat(input int a);
    return 18'((a * 1237 + 5) ^ (a << 11));
  endfunction

  function automatic logic [AW-1:0] m_addr();
    return {m_hi, m_base ^ m_cnt};
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check_out(input string tag);
    logic exp_en;
    exp_en = (m_cyc == 1) && !oe && !slp;
    checks++;
    if (dout_en !== exp_en) begin
      errors++;
      $display("FAIL %s: dout_en=%0b expected %0b", tag, dout_en, exp_en);
    end else if (exp_en && dout !== ref_mem[m_addr()]) begin
      errors++;
      $display("FAIL %s: dout=%h expected %h", tag, dout, ref_mem[m_addr()]);
    end
  endtask

  // apply the model for the current drive values, clock, then check
  task automatic tick(input string tag);
    logic chip, wr, ptk;
    logic [1:0] msk;
    int act, nc;
    chip = !s1 && !s2 && s3;
    wr   = !gw || (!bw && lw != 2'b11);
    msk  = !gw ? 2'b11 : (!bw ? ~lw : 2'b00);
    ptk  = !s1 && !pp;
    act = 0; nc = 0;
    if (ptk)          begin if (chip) begin nc = 1; act = 1; end end
    else if (!cc)     begin if (chip) begin nc = wr ? 2 : 1; act = 1; end end
    else if (m_cyc != 0) begin nc = wr ? 2 : 1; act = av ? 0 : 2; end
    if (!slp) begin
      if (act == 1) begin m_hi = ad[AW-1:2]; m_base = ad[1:0]; m_cnt = 2'd0; end
      else if (act == 2) m_cnt = m_cnt + 2'd1;
      m_cyc = nc;
      if (nc == 2) begin
        if (msk[0]) ref_mem[m_addr()][8:0]  = di[8:0];
        if (msk[1]) ref_mem[m_addr()][17:9] = di[17:9];
      end
    end
    @(posedge clk);
    #2;
    check_out(tag);
  endtask

  task automatic idle_pins();
    s1 = 0; s2 = 0; s3 = 1; pp = 1; cc = 1; av = 1;
    gw = 1; bw = 1; lw = 2'b11; oe = 0; slp = 0; di = '0;
  endtask

  task automatic ctrl_op(input int a, input logic wr_all, input logic [17:0] d, input string tag);
    idle_pins(); cc = 0; ad = AW'(a); gw = ~wr_all; di = d;
    tick(tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    idle_pins(); ad = '0; rst_n = 0;
    m_cyc = 0; m_hi = '0; m_base = '0; m_cnt = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) @(posedge clk);
    #2;
    // R11: idle after reset, output flag low even with oe low
    check_out("R11");
    idle_pins(); pp = 1; cc = 1; av = 0;
    tick("R11 continue after reset stays idle");

    // R4: fill every word through controller-strobe writes, then read back (R12)
    for (int a = 0; a < DEPTH; a++) ctrl_op(a, 1'b1, pat(a), "R4 write");
    for (int a = 0; a < DEPTH; a++) ctrl_op(a, 1'b0, '0, "R12 flow-through read");

    // R1: sweep enable patterns with both strobe kinds
    for (int e = 0; e < 8; e++) begin
      for (int k = 0; k < 2; k++) begin
        idle_pins(); s1 = e[0]; s2 = e[1]; s3 = e[2]; ad = AW'(e * 3 + k);
        if (k == 0) pp = 0; else cc = 0;
        tick("R1 select decode");
        idle_pins(); s1 = 1; s2 = 1; s3 = 0; av = 0;
        tick("R1 continue keeps state");
      end
    end

    // R3: processor strobe with write controls asserted still reads
    idle_pins(); pp = 0; ad = 6'd20; gw = 0; bw = 0; lw = 2'b00; di = 18'h15a5a;
    tick("R3 pstrb forces read");
    ctrl_op(20, 1'b0, '0, "R3 array unchanged");

    // R2: processor strobe with sel1_n high is ignored -> continue burst
    ctrl_op(8, 1'b0, '0, "R2 setup");
    idle_pins(); s1 = 1; pp = 0; ad = 6'd40; av = 0;
    tick("R2 pstrb ignored, burst steps");
    idle_pins(); s1 = 1; pp = 0; cc = 0; ad = 6'd41;
    tick("R2 ctrl strobe with sel1_n high deselects");

    // R5: every write-control combination at its own address
    for (int w = 0; w < 16; w++) begin
      idle_pins(); cc = 0; ad = AW'(44 + w % 16);
      gw = w[0]; bw = w[1]; lw = w[3:2]; di = ~pat(w + 100);
      tick("R5 write decode");
      ctrl_op(44 + w % 16, 1'b0, '0, "R5 lane readback");
    end

    // R6: interleaved bursts from each start offset, enables toggled
    for (int st = 0; st < 4; st++) begin
      idle_pins(); pp = 0; ad = AW'(32 + st);
      tick("R6 burst load");
      for (int n = 0; n < 4; n++) begin
        idle_pins(); av = 0; s1 = n[0]; s2 = ~n[1]; s3 = n[0];
        tick("R6 burst step");
      end
      // R7: suspend holds the address
      idle_pins(); av = 1; s3 = 0;
      tick("R7 suspend");
      tick("R7 suspend again");
    end

    // R8: write in the wait cycle after a processor-strobe read
    idle_pins(); pp = 0; ad = 6'd12;
    tick("R8 pstrb read");
    idle_pins(); av = 1; gw = 0; di = 18'h2c3d1;
    tick("R8 wait-cycle write");
    ctrl_op(12, 1'b0, '0, "R8 readback");

    // burst write then burst read (R6, R9)
    ctrl_op(4, 1'b1, 18'h01111, "R9 write no output");
    for (int n = 0; n < 3; n++) begin
      idle_pins(); av = 0; gw = 0; di = 18'h03000 + 18'(n);
      tick("R9 burst write keeps output off");
    end
    idle_pins(); pp = 0; ad = 6'd4;
    tick("R6 burst reread");
    for (int n = 0; n < 3; n++) begin idle_pins(); av = 0; tick("R6 burst reread step"); end

    // R9: oe high on a read
    idle_pins(); pp = 0; ad = 6'd5; oe = 1;
    tick("R9 oe high read");
    idle_pins(); oe = 0;
    tick("R9 oe low read");

    // R10: sleep
    idle_pins(); slp = 1; #1;
    checks++;
    if (dout_en !== 1'b0) begin
      errors++; $display("FAIL R10: dout_en=%0b expected 0", dout_en);
    end
    idle_pins(); slp = 1; cc = 0; ad = 6'd6; gw = 0; di = 18'h3ffff;
    tick("R10 sleep write blocked");
    idle_pins(); slp = 1; pp = 0; ad = 6'd7;
    tick("R10 sleep load blocked");
    idle_pins();
    tick("R10 state held after wake");
    ctrl_op(6, 1'b0, '0, "R10 array untouched");

    finish_up();
  end
endmodule